// File: doc/BRIEF.md
# Windowed Transmit FIFO with Commit

This block is the byte store that sits in front of a serial transmitter. The host fills it in two steps. It first writes bytes into a window, where each offset lands relative to the current write pointer. It then writes a byte count to a commit port. The transmitter sees nothing until that commit. A commit makes the written bytes visible, moves the write pointer and raises the fill count in a single cycle.

The transmit shifter removes committed bytes one per cycle through a pop request. The byte at the head of the queue is always present on the output. A status word carries both the fill count and the write pointer. From it the host can work out how much room is left and whether its next write starts on a 32-bit boundary.

Two flags follow the fill count: an empty flag, and a space-available flag with a 3-bit programmable low-water level. The block holds 1024 bytes, but it never queues more than 1020 of them.

Top module: `tx_win_fifo`

## Requirements
- R1: After reset the status word reads zero (fill count 0, write pointer 0), `tx_empty` is 1 and `space_avail` is 1.
- R2: A window write stores its byte at address (write pointer + `win_off`) mod 1024. It changes neither the fill count, nor the write pointer, nor `tx_empty`, until a commit is made.
- R3: A commit of N bytes, with N no larger than the free space, advances the write pointer by N modulo 1024 and raises the fill count by N. Both are visible in the status word in the cycle after the commit.
- R4: Free space is 1020 minus the fill count. A commit larger than the free space is clamped to the free space, so the fill count never exceeds 1020.
- R5: `pop_data` presents the oldest committed byte. Each cycle with `pop_req` high and a non-zero fill count removes one byte and lowers the fill count by one. Bytes leave in the order of their window addresses, including across the wrap from address 1023 to 0.
- R6: `pop_req` while the fill count is zero is ignored: the fill count stays 0 and the read position does not move.
- R7: With level k on `space_lvl` (3 bits), `space_avail` is 1 exactly when the fill count is at most 4·2^k bytes (level 0 gives 4, level 5 gives 128, level 7 gives 512).
- R8: The status word `ctrl_rdata` holds the fill count in bits 25:16 and the write pointer in bits 9:0. All other bits are zero.
- R9: A commit and a pop in the same cycle give a new fill count of old + granted − 1. The grant is clamped against the fill count as it was before the pop.
- R10: `tx_empty` is 1 exactly when the fill count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| win_we | input | 1 | Window byte write strobe |
| win_off | input | 10 | Byte offset from the current write pointer |
| win_data | input | 8 | Byte to store |
| commit_we | input | 1 | Commit strobe |
| commit_cnt | input | 10 | Number of bytes to commit |
| space_lvl | input | 3 | Low-water level k, threshold 4·2^k bytes |
| pop_req | input | 1 | Shifter takes the head byte this cycle |
| pop_data | output | 8 | Head byte of the queue |
| tx_empty | output | 1 | Fill count is zero |
| space_avail | output | 1 | Fill count at or below the low-water threshold |
| ctrl_rdata | output | 32 | Status word: fill count and write pointer |

## Verification
The hardest states to reach from the ports are a full queue, where commits are clamped, and a pointer wrap, where the payload straddles address 1023. To reach the clamp, the stimulus commits 1023 bytes into an empty queue without writing any data, and then retries a further commit. To reach the wrap, it commits and drains unchecked bulk counts until the write pointer sits just below 1024. It then writes a 40-byte payload through the window, commits it, and scoreboards the payload out through the pop port. The low-water thresholds and the same-cycle commit-and-pop are each driven at their exact boundaries.

// File: rtl/tx_win_pkg.sv
package tx_win_pkg;
  localparam int CTRL_W    = 32;
  localparam int FILL_LSB  = 16;
  localparam int WPTR_LSB  = 0;
  localparam int TRIG_UNIT = 4;

  function automatic int lvl_threshold(input int k);
    return TRIG_UNIT << k;
  endfunction
endpackage

// File: rtl/tx_win_rst_sync.sv
module tx_win_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/tx_win_store.sv
module tx_win_store #(
  parameter int DEPTH = 1024,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/tx_win_ctrl.sv
module tx_win_ctrl #(
  parameter int DEPTH    = 1024,
  parameter int HEADROOM = 4,
  localparam int AW      = $clog2(DEPTH),
  localparam int LIMIT   = DEPTH - HEADROOM
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit_we,
  input  logic [AW-1:0] commit_cnt,
  input  logic          pop_req,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [AW-1:0] fill
);
  localparam logic [AW:0] LIMIT_V = (AW+1)'(LIMIT);

  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d, fill_q, fill_d;
  logic [AW-1:0] grant;
  logic [AW:0]   free_sp;
  logic          pop_ok, upd_en;

  always_comb begin
    free_sp = LIMIT_V - {1'b0, fill_q};
    grant   = '0;
    if (commit_we)
      grant = ({1'b0, commit_cnt} > free_sp) ? free_sp[AW-1:0] : commit_cnt;
    pop_ok  = pop_req && (fill_q != '0);
    fill_d  = fill_q + grant - AW'(pop_ok);
    wptr_d  = wptr_q + grant;
    rptr_d  = rptr_q + AW'(pop_ok);
    upd_en  = commit_we || pop_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      fill_q <= '0;
    end else if (upd_en) begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      fill_q <= fill_d;
    end
  end

  assign wptr = wptr_q;
  assign rptr = rptr_q;
  assign fill = fill_q;
endmodule

// File: rtl/tx_win_level.sv
module tx_win_level #(
  parameter int AW    = 10,
  parameter int LVL_W = 3,
  localparam int NLVL = 1 << LVL_W
) (
  input  logic [AW-1:0]    fill,
  input  logic [LVL_W-1:0] lvl,
  output logic             space_avail
);
  import tx_win_pkg::*;

  logic [NLVL-1:0] hit;

  for (genvar k = 0; k < NLVL; k++) begin : g_thr
    localparam int THR = lvl_threshold(k);
    assign hit[k] = (int'(fill) <= THR);
  end

  assign space_avail = hit[lvl];
endmodule

// File: rtl/tx_win_fifo.sv
module tx_win_fifo #(
  parameter int DEPTH    = 1024,
  parameter int HEADROOM = 4,
  parameter int DW       = 8,
  parameter int LVL_W    = 3,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_we,
  input  logic [AW-1:0]    win_off,
  input  logic [DW-1:0]    win_data,
  input  logic             commit_we,
  input  logic [AW-1:0]    commit_cnt,
  input  logic [LVL_W-1:0] space_lvl,
  input  logic             pop_req,
  output logic [DW-1:0]    pop_data,
  output logic             tx_empty,
  output logic             space_avail,
  output logic [31:0]      ctrl_rdata
);
  import tx_win_pkg::*;

  logic          rst_n_sync;
  logic [AW-1:0] wptr, rptr, fill;
  logic [AW-1:0] win_addr;

  tx_win_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  tx_win_ctrl #(.DEPTH(DEPTH), .HEADROOM(HEADROOM)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .commit_we  (commit_we),
    .commit_cnt (commit_cnt),
    .pop_req    (pop_req),
    .wptr       (wptr),
    .rptr       (rptr),
    .fill       (fill)
  );

  assign win_addr = wptr + win_off;

  tx_win_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk     (clk),
    .wr_en   (win_we),
    .wr_addr (win_addr),
    .wr_data (win_data),
    .rd_addr (rptr),
    .rd_data (pop_data)
  );

  tx_win_level #(.AW(AW), .LVL_W(LVL_W)) u_level (
    .fill        (fill),
    .lvl         (space_lvl),
    .space_avail (space_avail)
  );

  assign tx_empty = (fill == '0);

  always_comb begin
    ctrl_rdata = '0;
    ctrl_rdata[FILL_LSB +: AW] = fill;
    ctrl_rdata[WPTR_LSB +: AW] = wptr;
  end
endmodule

// File: rtl/tx_win_fifo_chk.sv
module tx_win_fifo_chk #(
  parameter int AW    = 10,
  parameter int LIMIT = 1020,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             commit_we,
  input logic [AW-1:0]    commit_cnt,
  input logic             pop_req,
  input logic [LVL_W-1:0] space_lvl,
  input logic             tx_empty,
  input logic             space_avail,
  input logic [31:0]      ctrl_rdata
);
  logic [AW-1:0] fill_v;
  assign fill_v = ctrl_rdata[16 +: AW];

  // R3: an unclamped commit with no pop raises the fill count by the count
  a_r3_commit_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_we && !pop_req && (int'(commit_cnt) <= LIMIT - int'(fill_v)))
    |=> (int'(fill_v) == int'($past(fill_v)) + int'($past(commit_cnt))));

  // R4: the fill count never passes the limit
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill_v) <= LIMIT);

  // R5: a pop from a non-empty queue lowers the fill count by one
  a_r5_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !commit_we && !tx_empty) |=> (int'(fill_v) == int'($past(fill_v)) - 1));

  // R6: a pop on an empty queue leaves it empty
  a_r6_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !commit_we && tx_empty) |=> tx_empty);

  // R2: without commit or pop the status word does not move
  a_r2_window_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_we && !pop_req) |=> $stable(ctrl_rdata));

  // R7: the space flag agrees with the threshold
  a_r7_space_flag: assert property (@(posedge clk) disable iff (!rst_n)
    space_avail |-> (int'(fill_v) <= (4 << space_lvl)));

  // R10: empty flag matches a zero fill count
  a_r10_empty_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty == (fill_v == '0));

  // R8: unused status bits stay zero
  a_r8_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata[31:26] == '0) && (ctrl_rdata[15:10] == '0));
endmodule

bind tx_win_fifo tx_win_fifo_chk #(
  .AW(AW), .LIMIT(DEPTH - HEADROOM), .LVL_W(LVL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .commit_we   (commit_we),
  .commit_cnt  (commit_cnt),
  .pop_req     (pop_req),
  .space_lvl   (space_lvl),
  .tx_empty    (tx_empty),
  .space_avail (space_avail),
  .ctrl_rdata  (ctrl_rdata)
);

// File: tb/tx_win_fifo_tb_top.sv
`timescale 1ns/1ps
module tx_win_fifo_tb_top;
  localparam int DEPTH = 1024;
  localparam int AW    = 10;
  localparam int LIMIT = 1020;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          win_we;
  logic [AW-1:0] win_off;
  logic [7:0]    win_data;
  logic          commit_we;
  logic [AW-1:0] commit_cnt;
  logic [2:0]    space_lvl;
  logic          pop_req;
  logic [7:0]    pop_data;
  logic          tx_empty;
  logic          space_avail;
  logic [31:0]   ctrl_rdata;

  int checks = 0;
  int fails  = 0;
  bit sb_on  = 1'b0;
  logic [7:0] sb_q [$];
  logic [7:0] pend_q [$];
  int m_fill = 0;
  int m_wptr = 0;

  always #2 clk = ~clk;

  tx_win_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .win_we(win_we), .win_off(win_off),
    .win_data(win_data), .commit_we(commit_we), .commit_cnt(commit_cnt),
    .space_lvl(space_lvl), .pop_req(pop_req), .pop_data(pop_data),
    .tx_empty(tx_empty), .space_avail(space_avail), .ctrl_rdata(ctrl_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_stat(input string tag);
    chk({tag, " status"}, ctrl_rdata, (32'(m_fill) << 16) | 32'(m_wptr));
    chk({tag, " R10 empty"}, 32'(tx_empty), 32'(m_fill == 0));
  endtask

  // monitor: compares each popped byte against the scoreboard (R5)
  always @(negedge clk) begin
    #1;
    if (rst_n && pop_req && !tx_empty && sb_on) begin
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL R5 unexpected pop actual=0x%0h expected=none", pop_data);
      end else begin
        logic [7:0] e;
        e = sb_q.pop_front();
        if (pop_data !== e) begin
          fails++;
          $display("FAIL R5 pop data actual=0x%0h expected=0x%0h", pop_data, e);
        end
      end
    end
  end

  task automatic wr_byte(input int off, input logic [7:0] d);
    @(negedge clk);
    win_we = 1'b1; win_off = AW'(off); win_data = d;
    @(negedge clk);
    win_we = 1'b0;
    pend_q.push_back(d);
  endtask

  task automatic push_pending(input int eff);
    for (int i = 0; i < eff; i++)
      if (pend_q.size() > 0 && sb_on) sb_q.push_back(pend_q.pop_front());
    pend_q.delete();
  endtask

  task automatic commit(input int n);
    int eff;
    eff = (n > LIMIT - m_fill) ? LIMIT - m_fill : n;
    @(negedge clk);
    commit_we = 1'b1; commit_cnt = AW'(n);
    @(negedge clk);
    commit_we = 1'b0;
    m_fill += eff;
    m_wptr = (m_wptr + eff) % DEPTH;
    push_pending(eff);
  endtask

  task automatic frame(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) wr_byte(i, seed + 8'(i));
    commit(n);
  endtask

  task automatic pop_n(input int n);
    @(negedge clk);
    pop_req = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (m_fill > 0) m_fill--;
    end
    pop_req = 1'b0;
  endtask

  task automatic commit_and_pop(input int n);
    int eff;
    eff = (n > LIMIT - m_fill) ? LIMIT - m_fill : n;
    @(negedge clk);
    commit_we = 1'b1; commit_cnt = AW'(n); pop_req = 1'b1;
    @(negedge clk);
    commit_we = 1'b0; pop_req = 1'b0;
    m_fill = m_fill + eff - ((m_fill > 0) ? 1 : 0);
    m_wptr = (m_wptr + eff) % DEPTH;
    push_pending(eff);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; win_we = 1'b0; win_off = '0; win_data = '0;
    commit_we = 1'b0; commit_cnt = '0; space_lvl = 3'd5; pop_req = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 status", ctrl_rdata, 32'h0);
    chk("R1 empty", 32'(tx_empty), 32'd1);
    chk("R1 space", 32'(space_avail), 32'd1);

    // R2 window writes are invisible before commit
    sb_on = 1'b1;
    for (int i = 0; i < 3; i++) wr_byte(i, 8'hA0 + 8'(i));
    chk_stat("R2 before commit");

    // R3 / R8 commit moves pointer and fill
    commit(3);
    chk("R3 R8 status word", ctrl_rdata, (32'd3 << 16) | 32'd3);
    chk("R10 not empty", 32'(tx_empty), 32'd0);
    pop_n(3);
    chk_stat("R5 drained");

    // R6 pop while empty is ignored
    pop_n(3);
    chk_stat("R6 empty pop");
    frame(2, 8'h50);
    pop_n(2);
    chk_stat("R6 after refill");

    // R7 low-water thresholds
    frame(5, 8'h10);
    space_lvl = 3'd0; #1;
    chk("R7 fill5 lvl0", 32'(space_avail), 32'd0);
    space_lvl = 3'd1; #1;
    chk("R7 fill5 lvl1", 32'(space_avail), 32'd1);
    space_lvl = 3'd0;
    pop_n(1);
    chk("R7 fill4 lvl0", 32'(space_avail), 32'd1);
    pop_n(4);

    // R9 commit and pop together
    frame(3, 8'h30);
    wr_byte(0, 8'h77); wr_byte(1, 8'h78);
    commit_and_pop(2);
    chk_stat("R9 commit+pop");
    chk("R9 fill", 32'(ctrl_rdata[25:16]), 32'd4);
    pop_n(4);
    chk("R5 scoreboard empty", 32'(sb_q.size()), 32'd0);

    // R4 clamp at the limit, R7 at the top level
    sb_on = 1'b0;
    commit(1023);
    chk_stat("R4 clamp big commit");
    chk("R4 fill limit", 32'(ctrl_rdata[25:16]), 32'd1020);
    commit(5);
    chk_stat("R4 commit when full");
    space_lvl = 3'd7; #1;
    chk("R7 fill1020 lvl7", 32'(space_avail), 32'd0);
    pop_n(507);
    chk("R7 fill513 lvl7", 32'(space_avail), 32'd0);
    pop_n(1);
    chk("R7 fill512 lvl7", 32'(space_avail), 32'd1);
    pop_n(512);
    chk_stat("R4 drained");

    // R5 wrap of the pointers
    commit(1011 - m_wptr);
    pop_n(m_fill);
    chk_stat("R5 pre-wrap");
    sb_on = 1'b1;
    frame(40, 8'hC0);
    chk_stat("R5 R3 wrapped pointer");
    chk("R5 wptr wrap", 32'(ctrl_rdata[9:0]), 32'd27);
    pop_n(40);
    chk_stat("R5 post-wrap");
    chk("R5 scoreboard drained", 32'(sb_q.size()), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule